// File: doc/BRIEF.md
# Infrared Receive FIFO with Interrupt Status

This block is the register-side half of an infrared receiver. A run-length sampler in front of it pushes one byte per measured pulse or gap and raises a one-cycle marker when a packet ends. The block keeps those bytes in a byte FIFO and holds the sampler's configuration. Software reaches it through a simple register port with read and write strobes, an 8-bit offset and 32-bit data.

Reading the data port pops the oldest byte. A status word reports three sticky event flags and the live fill count. The flags are cleared by writing ones. A single level interrupt is raised when any flag is set and the matching enable bit is on.

The trigger level for the data-available event sits in the enable register. It is usually programmed to half the FIFO depth minus one.

Top module: `irrx_regfifo`

## Requirements
- R1: After reset every register reads 0, the FIFO is empty, `irq` is low and all configuration outputs are 0.
- R2: Offset 0x00 holds the global enable (bit 0), the receive enable (bit 1) and the mode field (bits 5:4, value 3 selects infrared receive). These bits drive `cfg_glb_en`, `cfg_rx_en` and `cfg_mode`, and other bits read back as 0.
- R3: Offset 0x10 bit 2 drives `cfg_invert`. Offset 0x34 holds the noise threshold (bits 7:2, driving `cfg_noise_thr`) and the idle threshold (bits 15:8, driving `cfg_idle_thr`). Other bits of both registers read back as 0.
- R4: Every register read returns its data on `reg_rdata` one cycle after the strobe. A read of offset 0x20 returns the oldest byte in bits 7:0 and removes it, so bytes come out in push order. A read of an empty FIFO returns 0 and leaves the count at 0.
- R5: The status word at offset 0x30 carries the current fill count in bits [8 +: log2(DEPTH)+1]. With DEPTH entries stored, this field reads DEPTH.
- R6: A push that arrives while the FIFO is full, with no pop in the same cycle, is dropped and sets the overflow flag (status bit 0). The stored bytes are left unchanged.
- R7: A push and a data-port pop in the same cycle on a full FIFO both take effect. The new byte is stored, the count stays at DEPTH and the overflow flag does not set.
- R8: A pulse on `samp_pkt_end` sets the packet-end flag (status bit 1).
- R9: The data-available flag (status bit 4) sets whenever the fill count exceeds the trigger level, which sits in offset 0x2C bits [8 +: log2(DEPTH)+1]. A clear cannot remove it while the count still exceeds the level.
- R10: Writing 1 to a status flag bit clears that flag, and writing 0 leaves it. Writing 0xFF clears all flags. A flag set event in the same cycle as its clear wins.
- R11: `irq` is high exactly when some flag is set and its enable bit at offset 0x2C is on. Bit 0 enables overflow, bit 1 enables packet end and bit 4 enables data available.
- R12: Writes to the data port and to unmapped offsets have no effect. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_push | input | 1 | Sampler byte strobe |
| samp_byte | input | 8 | Sampler byte |
| samp_pkt_end | input | 1 | Sampler packet-end pulse |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after a read strobe |
| irq | output | 1 | Level interrupt |
| cfg_glb_en | output | 1 | Global enable to the sampler |
| cfg_rx_en | output | 1 | Receive enable to the sampler |
| cfg_mode | output | 2 | Mode select to the sampler |
| cfg_invert | output | 1 | Input polarity inversion to the sampler |
| cfg_noise_thr | output | 6 | Noise threshold to the sampler |
| cfg_idle_thr | output | 8 | Idle threshold to the sampler |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a sampler push and a data-port pop while the FIFO holds DEPTH bytes. The bench raises both strobes in one cycle. It then checks that the popped byte is the oldest one, that the count and overflow flag are unchanged, and that a full drain returns the new byte last.

The second pair is a packet-end pulse and a clear-all write to the status register in the same cycle. The bench requires the packet-end flag to survive that write.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_RXCFG = 8'h10;
    localparam logic [7:0] OFS_DATA  = 8'h20;
    localparam logic [7:0] OFS_IEN   = 8'h2C;
    localparam logic [7:0] OFS_STAT  = 8'h30;
    localparam logic [7:0] OFS_SCFG  = 8'h34;

    localparam int BIT_OVF = 0;
    localparam int BIT_PKT = 1;
    localparam int BIT_DAV = 4;
    localparam int CNT_LSB = 8;

    typedef struct packed {
        logic dav;
        logic pkt;
        logic ovf;
    } evflags_t;
endpackage

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          ovf_evt
);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fst_t;

    fst_t q, d;
    logic full, pop_ok, push_ok;

    always_comb begin
        full    = (q.cnt == FULLV);
        empty   = (q.cnt == '0);
        pop_ok  = pop & ~empty;
        push_ok = push & (~full | pop_ok);
        ovf_evt = push & ~push_ok;
        d = q;
        if (push_ok) begin
            d.mem[q.wp] = push_data;
            d.wp        = q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head      = q.mem[q.rp];
    assign count     = q.cnt;
    assign count_nxt = d.cnt;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULLV); // R5
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (q.cnt == FULLV)); // R6
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full) |=> (q.cnt == FULLV && !$past(ovf_evt))); // R7
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (q.cnt == $past(q.cnt) - 1'b1)); // R4
endmodule

// File: rtl/irrx_csr.sv
module irrx_csr
    import irrx_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic [7:0]    fifo_head,
    input  logic          fifo_empty,
    input  logic [CW-1:0] fifo_cnt,
    input  logic [CW-1:0] fifo_cnt_nxt,
    input  logic          ovf_evt,
    input  logic          pkt_end_evt,
    output logic          fifo_pop,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          cfg_glb_en,
    output logic          cfg_rx_en,
    output logic [1:0]    cfg_mode,
    output logic          cfg_invert,
    output logic [5:0]    cfg_noise_thr,
    output logic [7:0]    cfg_idle_thr
);
    typedef struct packed {
        logic          glb;
        logic          rxe;
        logic [1:0]    mode;
        logic          inv;
        logic [5:0]    nthr;
        logic [7:0]    ithr;
        logic          ie_ovf;
        logic          ie_pkt;
        logic          ie_dav;
        logic [CW-1:0] lvl;
        evflags_t      fl;
        logic [31:0]   rdata;
    } cst_t;

    cst_t q, d;
    logic sel_ctrl, sel_rxcfg, sel_data, sel_ien, sel_stat, sel_scfg;
    logic [31:0] rd_mux;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[31:16];

    always_comb begin
        sel_ctrl  = (reg_addr == OFS_CTRL);
        sel_rxcfg = (reg_addr == OFS_RXCFG);
        sel_data  = (reg_addr == OFS_DATA);
        sel_ien   = (reg_addr == OFS_IEN);
        sel_stat  = (reg_addr == OFS_STAT);
        sel_scfg  = (reg_addr == OFS_SCFG);
        fifo_pop  = reg_rd & sel_data;

        d = q;
        if (reg_wr && sel_ctrl) begin
            d.glb  = reg_wdata[0];
            d.rxe  = reg_wdata[1];
            d.mode = reg_wdata[5:4];
        end
        if (reg_wr && sel_rxcfg) begin
            d.inv = reg_wdata[2];
        end
        if (reg_wr && sel_scfg) begin
            d.nthr = reg_wdata[7:2];
            d.ithr = reg_wdata[15:8];
        end
        if (reg_wr && sel_ien) begin
            d.ie_ovf = reg_wdata[BIT_OVF];
            d.ie_pkt = reg_wdata[BIT_PKT];
            d.ie_dav = reg_wdata[BIT_DAV];
            d.lvl    = reg_wdata[CNT_LSB +: CW];
        end

        d.fl.ovf = (q.fl.ovf & ~(reg_wr & sel_stat & reg_wdata[BIT_OVF])) | ovf_evt;
        d.fl.pkt = (q.fl.pkt & ~(reg_wr & sel_stat & reg_wdata[BIT_PKT])) | pkt_end_evt;
        d.fl.dav = (q.fl.dav & ~(reg_wr & sel_stat & reg_wdata[BIT_DAV]))
                 | (fifo_cnt_nxt > d.lvl);

        rd_mux = '0;
        if (sel_ctrl) begin
            rd_mux[0]   = q.glb;
            rd_mux[1]   = q.rxe;
            rd_mux[5:4] = q.mode;
        end
        if (sel_rxcfg) rd_mux[2] = q.inv;
        if (sel_scfg) begin
            rd_mux[7:2]  = q.nthr;
            rd_mux[15:8] = q.ithr;
        end
        if (sel_ien) begin
            rd_mux[BIT_OVF]       = q.ie_ovf;
            rd_mux[BIT_PKT]       = q.ie_pkt;
            rd_mux[BIT_DAV]       = q.ie_dav;
            rd_mux[CNT_LSB +: CW] = q.lvl;
        end
        if (sel_stat) begin
            rd_mux[BIT_OVF]       = q.fl.ovf;
            rd_mux[BIT_PKT]       = q.fl.pkt;
            rd_mux[BIT_DAV]       = q.fl.dav;
            rd_mux[CNT_LSB +: CW] = fifo_cnt;
        end
        if (sel_data && !fifo_empty) rd_mux[7:0] = fifo_head;
        if (reg_rd) d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_rdata     = q.rdata;
    assign irq           = (q.fl.ovf & q.ie_ovf) | (q.fl.pkt & q.ie_pkt) | (q.fl.dav & q.ie_dav);
    assign cfg_glb_en    = q.glb;
    assign cfg_rx_en     = q.rxe;
    assign cfg_mode      = q.mode;
    assign cfg_invert    = q.inv;
    assign cfg_noise_thr = q.nthr;
    assign cfg_idle_thr  = q.ithr;

    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> q.fl.ovf); // R6
    AST_PKT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end_evt |=> q.fl.pkt); // R8
    AST_DAV_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt > q.lvl) |-> q.fl.dav); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_stat && reg_wdata[BIT_PKT] && !pkt_end_evt) |=> !q.fl.pkt); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ie_ovf && !q.ie_pkt && !q.ie_dav) |-> !irq); // R11
endmodule

// File: rtl/irrx_regfifo.sv
module irrx_regfifo #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        samp_push,
    input  logic [7:0]  samp_byte,
    input  logic        samp_pkt_end,
    input  logic        reg_rd,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        cfg_glb_en,
    output logic        cfg_rx_en,
    output logic [1:0]  cfg_mode,
    output logic        cfg_invert,
    output logic [5:0]  cfg_noise_thr,
    output logic [7:0]  cfg_idle_thr
);
    logic          pop_w, empty_w, ovf_w;
    logic [7:0]    head_w;
    logic [CW-1:0] cnt_w, cnt_nxt_w;

    irrx_fifo #(.DEPTH(DEPTH), .DW(8)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (samp_push),
        .push_data (samp_byte),
        .pop       (pop_w),
        .head      (head_w),
        .empty     (empty_w),
        .count     (cnt_w),
        .count_nxt (cnt_nxt_w),
        .ovf_evt   (ovf_w)
    );

    irrx_csr #(.CW(CW)) csr_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .fifo_head     (head_w),
        .fifo_empty    (empty_w),
        .fifo_cnt      (cnt_w),
        .fifo_cnt_nxt  (cnt_nxt_w),
        .ovf_evt       (ovf_w),
        .pkt_end_evt   (samp_pkt_end),
        .fifo_pop      (pop_w),
        .reg_rdata     (reg_rdata),
        .irq           (irq),
        .cfg_glb_en    (cfg_glb_en),
        .cfg_rx_en     (cfg_rx_en),
        .cfg_mode      (cfg_mode),
        .cfg_invert    (cfg_invert),
        .cfg_noise_thr (cfg_noise_thr),
        .cfg_idle_thr  (cfg_idle_thr)
    );
endmodule

// File: tb/irrx_regfifo_tb_top.sv
`timescale 1ns/1ps
module irrx_regfifo_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_push = 1'b0, samp_pkt_end = 1'b0;
    logic [7:0]  samp_byte = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, cfg_glb_en, cfg_rx_en, cfg_invert;
    logic [1:0]  cfg_mode;
    logic [5:0]  cfg_noise_thr;
    logic [7:0]  cfg_idle_thr;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    irrx_regfifo #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .samp_push(samp_push), .samp_byte(samp_byte),
        .samp_pkt_end(samp_pkt_end), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .cfg_glb_en(cfg_glb_en), .cfg_rx_en(cfg_rx_en),
        .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
        .cfg_noise_thr(cfg_noise_thr), .cfg_idle_thr(cfg_idle_thr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); samp_push = 1'b1; samp_byte = b;
        @(negedge clk); samp_push = 1'b0;
    endtask

    task automatic pkt_pulse();
        @(negedge clk); samp_pkt_end = 1'b1;
        @(negedge clk); samp_pkt_end = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rreg(8'h30, v); chk("R1 status", v, 32'h0);
        rreg(8'h00, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 cfg outs", {cfg_glb_en, cfg_rx_en, cfg_mode, cfg_invert, cfg_noise_thr, cfg_idle_thr}, 32'h0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        wreg(8'h00, 32'hFFFF_FFFF);
        rreg(8'h00, v); chk("R2 ctrl readback", v, 32'h33);
        chk("R2 ctrl outs", {28'b0, cfg_glb_en, cfg_rx_en, cfg_mode}, 32'hF);
        wreg(8'h10, 32'hFFFF_FFFF);
        rreg(8'h10, v); chk("R3 rxcfg readback", v, 32'h4);
        chk("R3 invert", {31'b0, cfg_invert}, 32'h1);
        wreg(8'h34, 32'hFFFF_A5B7);
        rreg(8'h34, v); chk("R3 scfg readback", v, 32'hA5B4);
        chk("R3 thresholds", {18'b0, cfg_noise_thr, cfg_idle_thr}, {18'b0, 6'h2D, 8'hA5});
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wreg(8'h40, 32'hFFFF_FFFF);
        wreg(8'h20, 32'hFFFF_FFFF);
        rreg(8'h30, v); chk("R12 status after ignored writes", v, 32'h0);
        rreg(8'h00, v); chk("R12 ctrl unchanged", v, 32'h33);
        rreg(8'h40, v); chk("R12 unmapped read", v, 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] v;
        push(8'hA1); push(8'hB2); push(8'hC3);
        rreg(8'h30, v); chk("R5 count 3 with dav (R9 level 0)", v, 32'h310);
        rreg(8'h20, v); chk("R4 first byte", v, 32'hA1);
        rreg(8'h20, v); chk("R4 second byte", v, 32'hB2);
        rreg(8'h20, v); chk("R4 third byte", v, 32'hC3);
        rreg(8'h20, v); chk("R4 empty read", v, 32'h0);
        rreg(8'h30, v); chk("R4 count zero, dav sticky", v, 32'h10);
        wreg(8'h30, 32'h0);
        rreg(8'h30, v); chk("R10 zero write keeps flag", v, 32'h10);
        wreg(8'h30, 32'h10);
        rreg(8'h30, v); chk("R10 one write clears flag", v, 32'h0);
    endtask

    task automatic t_pkt_irq();
        logic [31:0] v;
        pkt_pulse();
        rreg(8'h30, v); chk("R8 packet-end flag", v, 32'h2);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        wreg(8'h2C, 32'h2);
        chk("R11 irq enabled", {31'b0, irq}, 32'h1);
        wreg(8'h30, 32'h2);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        wreg(8'h2C, 32'h711);
        for (int i = 0; i < 7; i++) push(8'h40 + 8'(i));
        rreg(8'h30, v); chk("R9 count equals level, no dav", v, 32'h700);
        chk("R11 irq low below level", {31'b0, irq}, 32'h0);
        push(8'h47);
        rreg(8'h30, v); chk("R9 count above level", v, 32'h810);
        chk("R11 irq on dav", {31'b0, irq}, 32'h1);
        for (int i = 8; i < 16; i++) push(8'h40 + 8'(i));
        rreg(8'h30, v); chk("R5 full count", v, 32'h1010);
        push(8'hEE);
        rreg(8'h30, v); chk("R6 overflow flag", v, 32'h1011);
        wreg(8'h30, 32'h01);
        rreg(8'h30, v); chk("R9 dav survives clear of ovf", v, 32'h1010);
        @(negedge clk); samp_push = 1'b1; samp_byte = 8'h99; reg_rd = 1'b1; reg_addr = 8'h20;
        @(negedge clk); samp_push = 1'b0; reg_rd = 1'b0; v = reg_rdata;
        chk("R7 pop during push returns oldest", v, 32'h40);
        rreg(8'h30, v); chk("R7 count and no ovf", v, 32'h1010);
        for (int i = 1; i < 16; i++) begin
            rreg(8'h20, v); chk("R6 drain order, dropped byte absent", v, 32'h40 + i);
        end
        rreg(8'h20, v); chk("R7 same-cycle byte last", v, 32'h99);
        rreg(8'h30, v); chk("R4 drained", v, 32'h10);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk); samp_pkt_end = 1'b1; reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 32'hFF;
        @(negedge clk); samp_pkt_end = 1'b0; reg_wr = 1'b0;
        rreg(8'h30, v); chk("R10 set beats clear-all", v, 32'h2);
        wreg(8'h30, 32'hFF);
        rreg(8'h30, v); chk("R10 clear-all", v, 32'h0);
    endtask

    task automatic t_dav_hold();
        logic [31:0] v;
        wreg(8'h2C, 32'h10);
        push(8'h5A);
        wreg(8'h30, 32'h10);
        rreg(8'h30, v); chk("R9 dav held while above level", v, 32'h110);
        rreg(8'h20, v); chk("R4 byte", v, 32'h5A);
        wreg(8'h30, 32'h10);
        rreg(8'h30, v); chk("R9 dav clears once below", v, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_unmapped();
        t_order();
        t_pkt_irq();
        t_overflow();
        t_set_wins();
        t_dav_hold();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule